// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block multiplies a stream of signed 8-bit activation vectors by a fixed N×N signed 8-bit weight matrix. The matrix is kept in a square grid of multiply-accumulate cells, one weight per cell. Each cell keeps its weight for as long as vectors are being processed. Activations move one cell to the right per clock. Partial sums start at zero on the top row, move one cell down per clock, and leave the bottom row as finished 32-bit dot products. No cell fetches an operand from anywhere other than its left and upper neighbours.

Weights are written one matrix row per cycle over N load beats. Once the last row is in, activation vectors can be presented at a rate of one per clock. Skew registers on the left edge delay row r by r cycles. De-skew registers on the bottom edge line the columns back up, so all N results of one vector leave together on a single valid beat. A vector flagged as the last of its batch carries that flag through to its output beat, and a one-cycle done pulse follows that beat. For a batch of M vectors, the last result leaves 2N−1+M cycles after the first vector is taken.

Top module: `ws_mac_grid`

## Requirements
- R1: After reset w_ready is low. A load beat is a cycle in which w_load is high and no result is in flight. Load beat k (k = 0..N−1) writes w_row bits [8c+7:8c] into the cell at row k, column c. w_ready goes low after the first beat of a load and goes high in the cycle after the N-th beat.
- R2: An activation vector is accepted only in a cycle with act_valid high, w_ready high and w_load low. A vector presented in any other cycle produces no output beat.
- R3: For an accepted vector x, where element r is act_vec bits [8r+7:8r] as a signed byte, out_data bits [32c+31:32c] equal the 32-bit two's complement value of the sum over r of x[r]·W[r][c].
- R4: Each accepted vector produces exactly one output beat, with out_valid high for one cycle, 2N cycles after the cycle in which it was accepted. Beats appear in acceptance order, and back-to-back vectors give back-to-back beats.
- R5: out_last is high on the beat of a vector that was accepted with act_last high, and on no other beat. done is high for exactly the one cycle after each such beat.
- R6: A cycle with w_load high while a result is in flight has no effect: the stored weights and w_ready stay as they were.
- R7: Stored weights stay in place across any number of batches until load beats overwrite them.
- R8: out_data is zero after reset and changes only on a cycle in which out_valid is high.
- R9: Accumulation is exact at the extremes of the operand range. For example, with N = 4, all weights −128 and all activations −128 give 65536 in every column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_load | input | 1 | Weight load beat request |
| w_row | input | N*8 | One weight row, column c at bits [8c+7:8c] |
| w_ready | output | 1 | Full weight matrix is loaded |
| act_valid | input | 1 | Activation vector present |
| act_last | input | 1 | Vector is the last of its batch |
| act_vec | input | N*8 | Activation vector, element r at bits [8r+7:8r] |
| out_valid | output | 1 | Result beat |
| out_last | output | 1 | Beat belongs to the last vector of a batch |
| out_data | output | N*32 | Column results, column c at bits [32c+31:32c] |
| done | output | 1 | One-cycle pulse after the last beat of a batch |

## Verification
The bench builds the grid with N = 4 and 32-bit sums. With N = 4 the whole 2N-cycle latency, the 2N−1-deep in-flight window and a 3N-vector back-to-back batch all fit in a few dozen cycles. The all −128 corner also reaches its exact value of 65536. With this size, reload attempts can be placed inside the in-flight window, refused vectors can be placed between load beats, and batches of 1 and 12 vectors can be run.

// File: rtl/ws_mac_pkg.sv
package ws_mac_pkg;

  // Per-vector tag that travels alongside the data wavefront.
  typedef struct packed {
    logic valid;
    logic last;
  } tag_t;

endpackage

// File: rtl/ws_delay_line.sv
module ws_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk;
      assign q = d;
    end else begin : g_shift
      // Plain shift register with no reset, so it can map to shift-register LUTs.
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk) begin
        sr[0] <= d;
        for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/ws_mac_cell.sv
module ws_mac_cell #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 w_we,
  input  logic [DW-1:0]        w_in,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [AW-1:0] p_in,
  output logic signed [DW-1:0] a_out,
  output logic signed [AW-1:0] p_out
);

  localparam int PW = 2 * DW;

  logic signed [DW-1:0] w_q;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = w_q * a_in;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      a_out <= '0;
      p_out <= '0;
    end else begin
      if (w_we) w_q <= w_in;
      a_out <= a_in;
      p_out <= p_in + prod_ext;
    end
  end

endmodule

// File: rtl/ws_load_ctrl.sv
module ws_load_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_go,
  output logic [N-1:0] row_we,
  output logic         ready
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt;

  always_comb begin
    for (int r = 0; r < N; r++) row_we[r] = load_go && (cnt == CW'(r));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (load_go) begin
      if (cnt == CW'(N-1)) begin
        cnt   <= '0;
        ready <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        ready <= 1'b0;
      end
    end
  end

  // R1
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(load_go) && $past(cnt) == CW'(N-1)));

  // R1
  ready_low_mid_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_go && cnt != CW'(N-1)) |=> !ready);

endmodule

// File: rtl/ws_tag_pipe.sv
module ws_tag_pipe
  import ws_mac_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  tag_t tag_in,
  output tag_t tag_out,
  output logic busy
);

  tag_t st [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= tag_in;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) busy = busy | st[i].valid;
  end

  assign tag_out = st[DEPTH-1];

  // R5
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tag_out.last |-> tag_out.valid);

endmodule

// File: rtl/ws_mac_grid.sv
module ws_mac_grid
  import ws_mac_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          w_load,
  input  logic [N*DW-1:0] w_row,
  output logic          w_ready,
  input  logic          act_valid,
  input  logic          act_last,
  input  logic [N*DW-1:0] act_vec,
  output logic          out_valid,
  output logic          out_last,
  output logic [N*AW-1:0] out_data,
  output logic          done
);

  // Cycles from acceptance until the de-skewed column results line up.
  localparam int LAT = 2 * N - 1;

  logic         busy;
  logic         load_go;
  logic         take;
  logic [N-1:0] row_we;
  tag_t         tag_in;
  tag_t         tag_out;

  assign load_go = w_load & ~busy;
  assign take    = act_valid & w_ready & ~w_load;
  assign tag_in  = '{valid: take, last: take & act_last};

  ws_load_ctrl #(.N(N)) u_load (
    .clk    (clk),
    .rst    (rst),
    .load_go(load_go),
    .row_we (row_we),
    .ready  (w_ready)
  );

  ws_tag_pipe #(.DEPTH(LAT)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .tag_in (tag_in),
    .tag_out(tag_out),
    .busy   (busy)
  );

  logic [DW-1:0]        edge_a  [N];
  logic signed [DW-1:0] a_q     [N][N];
  logic signed [AW-1:0] p_q     [N][N];
  logic [AW-1:0]        col_res [N];
  logic [N*AW-1:0]      col_flat;
  logic [N*DW-1:0]      unused_tail;

  // Left-edge skew: row r enters r cycles late.
  for (genvar r = 0; r < N; r++) begin : g_skew
    ws_delay_line #(.W(DW), .DEPTH(r)) u_skew (
      .clk(clk),
      .d  (take ? act_vec[r*DW +: DW] : '0),
      .q  (edge_a[r])
    );
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [DW-1:0] a_in;
      logic signed [AW-1:0] p_in;
      if (c == 0) begin : g_left
        assign a_in = edge_a[r];
      end else begin : g_inner_a
        assign a_in = a_q[r][c-1];
      end
      if (r == 0) begin : g_top
        assign p_in = '0;
      end else begin : g_inner_p
        assign p_in = p_q[r-1][c];
      end
      ws_mac_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk  (clk),
        .rst  (rst),
        .w_we (row_we[r]),
        .w_in (w_row[c*DW +: DW]),
        .a_in (a_in),
        .p_in (p_in),
        .a_out(a_q[r][c]),
        .p_out(p_q[r][c])
      );
    end
    assign unused_tail[r*DW +: DW] = a_q[r][N-1];
  end

  // Bottom-edge de-skew: column c waits N-1-c cycles.
  for (genvar c = 0; c < N; c++) begin : g_dsk
    ws_delay_line #(.W(AW), .DEPTH(N-1-c)) u_dsk (
      .clk(clk),
      .d  (p_q[N-1][c]),
      .q  (col_res[c])
    );
    assign col_flat[c*AW +: AW] = col_res[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= tag_out.valid;
      out_last  <= tag_out.valid & tag_out.last;
      done      <= out_valid & out_last;
      if (tag_out.valid) out_data <= col_flat;
    end
  end

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_last));

  // R6
  ready_during_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> w_ready);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R5
  last_only_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

endmodule

// File: tb/ws_mac_grid_tb_top.sv
module ws_mac_grid_tb_top;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            w_load = 1'b0;
  logic [N*DW-1:0] w_row = '0;
  logic            w_ready;
  logic            act_valid = 1'b0;
  logic            act_last = 1'b0;
  logic [N*DW-1:0] act_vec = '0;
  logic            out_valid;
  logic            out_last;
  logic [N*AW-1:0] out_data;
  logic            done;

  always #10 clk = ~clk;

  ws_mac_grid #(.N(N), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .w_load(w_load), .w_row(w_row), .w_ready(w_ready),
    .act_valid(act_valid), .act_last(act_last), .act_vec(act_vec),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int n_beats = 0;
  int n_done  = 0;
  int n_batch = 0;
  bit model_ready = 1'b0;
  bit prev_lastbeat = 1'b0;
  logic [N*AW-1:0] last_data = '0;

  logic signed [DW-1:0] wm   [N][N];
  logic signed [DW-1:0] wnew [N][N];

  logic [N*AW-1:0] exp_data_q [$];
  int              exp_cyc_q  [$];
  bit              exp_last_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [N*AW-1:0] act, logic [N*AW-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic [N*AW-1:0] ref_mul(logic [N*DW-1:0] x);
    logic [N*AW-1:0] y;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      for (int r = 0; r < N; r++)
        s += int'($signed(x[r*DW +: DW])) * int'(wm[r][c]);
      y[c*AW +: AW] = s;
    end
    return y;
  endfunction

  // Output monitor: sampled on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) n_done++;
      if (done || prev_lastbeat)
        chk(done == prev_lastbeat, "R5", "done pulse", N*AW'(done), N*AW'(prev_lastbeat));
      if (out_valid) begin
        n_beats++;
        if (exp_data_q.size() == 0) begin
          chk(1'b0, "R2", "beat with nothing accepted", out_data, '0);
        end else begin
          logic [N*AW-1:0] e;
          int ec;
          bit el;
          e  = exp_data_q.pop_front();
          ec = exp_cyc_q.pop_front();
          el = exp_last_q.pop_front();
          chk(out_data == e, "R3", "column results", out_data, e);
          chk(cyc == ec, "R4", "beat cycle", N*AW'(cyc), N*AW'(ec));
          chk(out_last == el, "R5", "last flag", N*AW'(out_last), N*AW'(el));
        end
        last_data = out_data;
      end else begin
        chk(out_data == last_data, "R8", "data held between beats", out_data, last_data);
      end
      prev_lastbeat = out_valid && out_last;
    end
  end

  task automatic idle(int k);
    repeat (k) begin
      @(negedge clk);
      act_valid = 1'b0;
      act_last  = 1'b0;
      w_load    = 1'b0;
    end
  endtask

  task automatic drain();
    while (exp_data_q.size() != 0) idle(1);
    idle(3);
  endtask

  task automatic send(logic [N*DW-1:0] x, bit last);
    @(negedge clk);
    w_load    = 1'b0;
    act_valid = 1'b1;
    act_last  = last;
    act_vec   = x;
    if (model_ready) begin
      exp_data_q.push_back(ref_mul(x));
      exp_cyc_q.push_back(cyc + 2*N);
      exp_last_q.push_back(last);
      if (last) n_batch++;
    end
  endtask

  function automatic logic [N*DW-1:0] rand_vec();
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  // R1: load beat k writes row k, element c at bits [8c+7:8c].
  task automatic load_w(bit probe);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = wnew[r][c];
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      act_valid = 1'b0;
      w_load    = 1'b1;
      for (int c = 0; c < N; c++) w_row[c*DW +: DW] = wnew[r][c];
      model_ready = 1'b0;
      if (probe && r == 1) begin
        @(negedge clk);
        w_load    = 1'b0;
        act_valid = 1'b1;
        act_vec   = rand_vec();
        // R2: vector presented while the load is incomplete is refused
        chk(w_ready == 1'b0, "R1", "ready low mid-load", N*AW'(w_ready), '0);
      end
    end
    @(negedge clk);
    w_load    = 1'b0;
    act_valid = 1'b0;
    model_ready = 1'b1;
    chk(w_ready == 1'b1, "R1", "ready after N beats", N*AW'(w_ready), 1);
  endtask

  task automatic rand_weights();
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wnew[r][c] = DW'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = '0;
    repeat (4) @(negedge clk);
    // R1 / R8 reset state
    chk(w_ready == 1'b0, "R1", "ready after reset", N*AW'(w_ready), '0);
    chk(out_valid == 1'b0 && done == 1'b0, "R8", "no beat in reset", N*AW'({out_valid, done}), '0);
    chk(out_data == '0, "R8", "data zero after reset", out_data, '0);
    rst = 1'b0;

    // R2: vectors before any load are refused
    send(rand_vec(), 1'b1);
    send(rand_vec(), 1'b0);
    idle(2*N + 4);
    chk(n_beats == 0, "R2", "no beat before load", N*AW'(n_beats), '0);

    // R1 load with a refused vector between beats
    rand_weights();
    load_w(1'b1);
    idle(2*N + 2);
    chk(n_beats == 0, "R2", "no beat from mid-load vector", N*AW'(n_beats), '0);

    // R5 batch of one
    send(rand_vec(), 1'b1);
    drain();
    chk(n_done == 1, "R5", "done after batch of one", N*AW'(n_done), 1);

    // R4 batch of 3N back-to-back
    for (int i = 0; i < 3*N; i++) send(rand_vec(), i == 3*N-1);
    drain();
    chk(n_beats == 3*N + 1, "R4", "beats for 3N batch", N*AW'(n_beats), N*AW'(3*N + 1));

    // R6: reload attempts while results are in flight, with a vector presented alongside (R2)
    send(rand_vec(), 1'b1);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      w_load    = 1'b1;
      act_valid = 1'b1;
      act_last  = 1'b0;
      act_vec   = rand_vec();
      w_row     = rand_vec();
    end
    idle(1);
    drain();
    chk(w_ready == 1'b1, "R6", "ready unchanged by refused load", N*AW'(w_ready), 1);

    // R7: weights kept across batches without reload
    for (int i = 0; i < N; i++) send(rand_vec(), i == N-1);
    drain();

    // Random rounds: fresh weights, random batch lengths, random gaps
    for (int rnd = 0; rnd < 6; rnd++) begin
      int len;
      rand_weights();
      load_w(rnd[0]);
      for (int b = 0; b < 3; b++) begin
        len = 1 + int'($urandom % (2*N));
        for (int i = 0; i < len; i++) begin
          send(rand_vec(), i == len-1);
          if (($urandom % 4) == 0) idle(1 + int'($urandom % 3));
        end
      end
      drain();
    end

    // R9 extremes: all weights -128
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wnew[r][c] = -8'sd128;
    load_w(1'b0);
    send({N{8'h80}}, 1'b0);
    send({N{8'h7F}}, 1'b1);
    drain();
    chk(last_data[AW-1:0] == AW'(-16256 * N), "R9", "max negative sum", last_data[AW-1:0], AW'(-16256 * N));
    send({N{8'h80}}, 1'b1);
    drain();
    chk(last_data[AW-1:0] == AW'(16384 * N), "R9", "max positive sum", last_data[AW-1:0], AW'(16384 * N));

    idle(2);
    chk(exp_data_q.size() == 0, "R4", "every accepted vector produced a beat",
        N*AW'(exp_data_q.size()), '0);
    chk(n_done == n_batch, "R5", "one done per batch", N*AW'(n_done), N*AW'(n_batch));
    report();
  end

endmodule